// File: doc/BRIEF.md
# Mode-Gated Memory-Mapped Bus Decoder

This block sits between a 32-bit CPU data bus and everything the CPU can reach. Each request carries an address, a write enable, write data and byte strobes. The block turns it into exactly one select strobe: to the boot ROM, to the main RAM, or to one of six memory-mapped peripheral cores. It also serves a small system core of its own. It returns one registered response per request, with read data and an access-denied flag.

The system core holds a one-way mode latch. Out of reset the device runs privileged boot code. Once that code writes a non-zero value to the mode-switch word, the latch moves to the restricted application mode and only a reset brings it back. In restricted mode the secret-key core and the private boot RAM disappear from the map, and the mode-switch word cannot be reached. The loaded-image base and length words become read-only, as do the eight derived-identity words. Every access that the current mode forbids, and every access to an address with no target, reads zero, changes nothing and is reported as denied.

Top module: `mmio_gate`

## Requirements
- R1: Address bits [31:30] choose the region. 00 asserts `sel_rom`, 01 asserts `sel_ram`, 10 is reserved and 11 is the peripheral region. At most one select is high, and only in a cycle where `req_valid` is high.
- R2: In the peripheral region, address bits [31:24] pick the core: 0xC0 `core_sel[0]` (entropy), 0xC1 `core_sel[1]` (timer), 0xC2 `core_sel[2]` (secret key), 0xC3 `core_sel[3]` (serial), 0xC4 `core_sel[4]` (touch), 0xD0 `core_sel[5]` (private RAM), and 0xFF the internal system core. 0xFF drives no select.
- R3: `req_ready` is always high. Every request gives `rsp_valid` for exactly one cycle, on the clock edge after the request. `rsp_rdata` is the addressed source's data as it was in the request cycle, and zero for writes.
- R4: A write to system word 0x10 whose strobed bytes are not all zero sets `app_mode`, visible after that edge. A zero write leaves the mode unchanged. Only reset clears `app_mode`.
- R5: While `app_mode` is high, accesses to the secret-key core (0xC2) and the private RAM (0xD0) assert no select and are denied. Accesses to system word 0x10 are also denied.
- R6: System words 0x20 (image base) and 0x24 (image length) reset to zero. They can be read in either mode. In boot mode they are written byte by byte under `req_strb`. In `app_mode` a write is denied and leaves the value unchanged.
- R7: System words 0x40 to 0x5C hold the eight derived-identity words. They reset to zero and follow the same rules as R6.
- R8: System words 0x00, 0x04 and 0x08 read 0x3161746D, 0x66646B6D and 0x00000001 in both modes. A write to them is denied and has no effect.
- R9: A denied access reads zero and raises `rsp_denied` for one cycle, together with `rsp_valid`. The reserved region is denied. So are unassigned core prefixes, and system-core offsets that are unassigned, misaligned or have non-zero bits [23:8].
- R10: In boot mode a read of system word 0x10 returns zero and is not denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (constant high) |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | Write when high |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte write strobes |
| sel_rom | output | 1 | Boot ROM select |
| sel_ram | output | 1 | Main RAM select |
| core_sel | output | 6 | Peripheral core selects |
| rom_rdata | input | 32 | ROM read data |
| ram_rdata | input | 32 | RAM read data |
| core_rdata | input | 192 | Core read data, core i in bits [32i+31:32i] |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Response read data |
| rsp_denied | output | 1 | Access refused |
| app_mode | output | 1 | Restricted mode latched |

## Verification
Selects are combinational, so the bench samples them 1 ns after driving a request, in the request cycle itself. The response, the denied flag and every register update appear on the next rising edge, so they are sampled at the falling edge one cycle after the request. A mode change or register write can first be seen by the next request. The bench model updates its state only after it has computed the expectation for the current request, which keeps to that one-cycle order.

// File: rtl/mmio_gate_pkg.sv
// Package: shared types and constants of the mode-gated bus decoder.
// Assumes a 32-bit byte address and 32-bit data.
package mmio_gate_pkg;
    localparam int DATA_W    = 32;
    localparam int STRB_W    = DATA_W / 8;
    localparam int NCORES    = 6;
    localparam int CDI_WORDS = 8;
    localparam int WORD_W    = 6;

    // core index assignment
    localparam int CORE_TRNG  = 0;
    localparam int CORE_TIMER = 1;
    localparam int CORE_KEY   = 2;
    localparam int CORE_UART  = 3;
    localparam int CORE_TOUCH = 4;
    localparam int CORE_PRAM  = 5;

    localparam logic [7:0] CORE_PREFIX [NCORES] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hD0};
    localparam logic [7:0] SYS_PREFIX = 8'hFF;

    // system core word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_ID0    = 6'd0;
    localparam logic [WORD_W-1:0] W_ID1    = 6'd1;
    localparam logic [WORD_W-1:0] W_VER    = 6'd2;
    localparam logic [WORD_W-1:0] W_SWITCH = 6'd4;
    localparam logic [WORD_W-1:0] W_BASE   = 6'd8;
    localparam logic [WORD_W-1:0] W_LEN    = 6'd9;
    localparam int                W_CDI0   = 16;

    localparam logic [DATA_W-1:0] ID0_VAL = 32'h3161_746D;
    localparam logic [DATA_W-1:0] ID1_VAL = 32'h6664_6B6D;
    localparam logic [DATA_W-1:0] VER_VAL = 32'h0000_0001;

    typedef enum logic [1:0] {
        RG_ROM  = 2'b00,
        RG_RAM  = 2'b01,
        RG_RSVD = 2'b10,
        RG_MMIO = 2'b11
    } region_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ROM,
        TGT_RAM,
        TGT_CORE,
        TGT_SYS
    } target_e;
endpackage

// File: rtl/mmio_region_dec.sv
// Module: address decoder. Maps an address to a target class and a one-hot
// core hit vector. Purely combinational; assumes core prefixes are distinct.
module mmio_region_dec
    import mmio_gate_pkg::*;
(
    input  logic [7:0]        addr_hi,
    output target_e           tgt,
    output logic [NCORES-1:0] core_hit
);
    logic is_sys;

    // one comparator per core prefix
    for (genvar g = 0; g < NCORES; g++) begin : g_hit
        assign core_hit[g] = (addr_hi == CORE_PREFIX[g]);
    end

    assign is_sys = (addr_hi == SYS_PREFIX);

    // region select from the top two bits, then core class
    always_comb begin
        unique case (region_e'(addr_hi[7:6]))
            RG_ROM:  tgt = TGT_ROM;
            RG_RAM:  tgt = TGT_RAM;
            RG_RSVD: tgt = TGT_NONE;
            default: tgt = (|core_hit) ? TGT_CORE : (is_sys ? TGT_SYS : TGT_NONE);
        endcase
    end
endmodule

// File: rtl/mmio_access_policy.sv
// Module: access rights. Decides from target, offset, direction and mode
// whether an access proceeds or is denied. Combinational; assumes the
// offset fields are taken from an aligned word address.
module mmio_access_policy
    import mmio_gate_pkg::*;
(
    input  target_e           tgt,
    input  logic [NCORES-1:0] core_hit,
    input  logic [WORD_W-1:0] word,
    input  logic              off_ok,
    input  logic              we,
    input  logic              app_mode,
    output logic              deny,
    output logic              sys_wr
);
    logic is_id, is_sw, is_img, is_cdi, known, hidden_core;

    // classify system-core words
    always_comb begin
        is_id  = (word == W_ID0) || (word == W_ID1) || (word == W_VER);
        is_sw  = (word == W_SWITCH);
        is_img = (word == W_BASE) || (word == W_LEN);
        is_cdi = (int'(word) >= W_CDI0) && (int'(word) < W_CDI0 + CDI_WORDS);
        known  = off_ok && (is_id || is_sw || is_img || is_cdi);
    end

    assign hidden_core = app_mode && (core_hit[CORE_KEY] || core_hit[CORE_PRAM]);

    // decision per target class
    always_comb begin
        unique case (tgt)
            TGT_ROM, TGT_RAM: deny = 1'b0;
            TGT_CORE:         deny = hidden_core;
            TGT_SYS:          deny = !known
                                  || (is_id && we)
                                  || (is_sw && app_mode)
                                  || ((is_img || is_cdi) && we && app_mode);
            default:          deny = 1'b1;
        endcase
    end

    assign sys_wr = (tgt == TGT_SYS) && we && !deny;
endmodule

// File: rtl/mmio_sys_regs.sv
// Module: system core registers. Holds the one-way mode latch, the image
// base/length words and the identity words, and serves reads. Assumes
// wr_en is already qualified by the access policy.
module mmio_sys_regs
    import mmio_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    output logic              app_mode,
    output logic [DATA_W-1:0] rdata
);
    localparam int CDI_IDX_W = (CDI_WORDS > 1) ? $clog2(CDI_WORDS) : 1;

    logic [DATA_W-1:0] img_base, img_len;
    logic [DATA_W-1:0] cdi [CDI_WORDS];
    logic [DATA_W-1:0] bmask;

    // byte strobes widened to a bit mask
    always_comb begin
        for (int b = 0; b < STRB_W; b++) bmask[b*8 +: 8] = {8{strb[b]}};
    end

    // mode latch: set by a non-zero switch write, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                               app_mode <= 1'b0;
        else if (wr_en && word == W_SWITCH && |(wdata & bmask))   app_mode <= 1'b1;
    end

    // image base and length words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_base <= '0;
            img_len  <= '0;
        end else if (wr_en && word == W_BASE) begin
            img_base <= (img_base & ~bmask) | (wdata & bmask);
        end else if (wr_en && word == W_LEN) begin
            img_len  <= (img_len & ~bmask) | (wdata & bmask);
        end
    end

    // identity words, one register per index
    for (genvar g = 0; g < CDI_WORDS; g++) begin : g_cdi
        always_ff @(posedge clk) begin
            if (!rst_n)                                 cdi[g] <= '0;
            else if (wr_en && int'(word) == W_CDI0 + g) cdi[g] <= (cdi[g] & ~bmask) | (wdata & bmask);
        end
    end

    // read multiplexer
    always_comb begin
        logic [CDI_IDX_W-1:0] ci;
        ci = CDI_IDX_W'(int'(word) - W_CDI0);
        if (word == W_ID0)                                                 rdata = ID0_VAL;
        else if (word == W_ID1)                                            rdata = ID1_VAL;
        else if (word == W_VER)                                            rdata = VER_VAL;
        else if (word == W_BASE)                                           rdata = img_base;
        else if (word == W_LEN)                                            rdata = img_len;
        else if (int'(word) >= W_CDI0 && int'(word) < W_CDI0 + CDI_WORDS)  rdata = cdi[ci];
        else                                                               rdata = '0;
    end

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) app_mode |=> app_mode); // R4
    AST_IMG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> ($stable(img_base) && $stable(img_len))); // R6
    AST_CDI0_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> $stable(cdi[0])); // R7
endmodule

// File: rtl/mmio_gate.sv
// Module: top of the mode-gated bus decoder. Accepts one request per cycle
// (always ready), drives combinational selects in the request cycle and a
// registered response one cycle later. Assumes stubs or cores answer reads
// combinationally in the request cycle.
module mmio_gate
    import mmio_gate_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [31:0]              req_addr,
    input  logic                     req_we,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [STRB_W-1:0]        req_strb,
    output logic                     sel_rom,
    output logic                     sel_ram,
    output logic [NCORES-1:0]        core_sel,
    input  logic [DATA_W-1:0]        rom_rdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    input  logic [NCORES*DATA_W-1:0] core_rdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_denied,
    output logic                     app_mode
);
    target_e           tgt;
    logic [NCORES-1:0] core_hit;
    logic              deny, sys_wr, off_ok;
    logic [DATA_W-1:0] sys_rdata, mux_rdata;

    assign req_ready = 1'b1;
    assign off_ok    = (req_addr[23:8] == '0) && (req_addr[1:0] == 2'b00);

    mmio_region_dec u_dec (
        .addr_hi  (req_addr[31:24]),
        .tgt      (tgt),
        .core_hit (core_hit)
    );

    mmio_access_policy u_pol (
        .tgt      (tgt),
        .core_hit (core_hit),
        .word     (req_addr[7:2]),
        .off_ok   (off_ok),
        .we       (req_we),
        .app_mode (app_mode),
        .deny     (deny),
        .sys_wr   (sys_wr)
    );

    mmio_sys_regs u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (req_valid && sys_wr),
        .word     (req_addr[7:2]),
        .wdata    (req_wdata),
        .strb     (req_strb),
        .app_mode (app_mode),
        .rdata    (sys_rdata)
    );

    // select strobes for permitted accesses
    always_comb begin
        sel_rom  = req_valid && !deny && (tgt == TGT_ROM);
        sel_ram  = req_valid && !deny && (tgt == TGT_RAM);
        core_sel = (req_valid && !deny && tgt == TGT_CORE) ? core_hit : '0;
    end

    // read data source selection, forced to zero for writes and denials
    always_comb begin
        mux_rdata = '0;
        unique case (tgt)
            TGT_ROM: mux_rdata = rom_rdata;
            TGT_RAM: mux_rdata = ram_rdata;
            TGT_SYS: mux_rdata = sys_rdata;
            TGT_CORE: begin
                for (int i = 0; i < NCORES; i++)
                    if (core_hit[i]) mux_rdata = core_rdata[i*DATA_W +: DATA_W];
            end
            default: mux_rdata = '0;
        endcase
        if (deny || req_we) mux_rdata = '0;
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_denied <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_rdata  <= req_valid ? mux_rdata : '0;
            rsp_denied <= req_valid && deny;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_sel, sel_ram, sel_rom})); // R1
    AST_HIDDEN_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |-> (!core_sel[CORE_KEY] && !core_sel[CORE_PRAM])); // R5
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3
    AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_valid && rsp_rdata == '0)); // R9
endmodule

// File: tb/mmio_gate_bench.sv
module mmio_gate_bench;
    localparam int NC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [31:0] req_addr = '0;
    logic req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0] req_strb = '0;
    logic sel_rom, sel_ram;
    logic [NC-1:0] core_sel;
    logic [31:0] rom_rdata, ram_rdata;
    logic [NC*32-1:0] core_rdata;
    logic rsp_valid, rsp_denied, app_mode;
    logic [31:0] rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // model state
    bit          m_mode;
    logic [31:0] m_base, m_len;
    logic [31:0] m_cdi [8];

    always #4 clk = ~clk;

    // stub responders: data derived from the address
    always_comb begin
        rom_rdata = req_addr ^ 32'h5A5A_0000;
        ram_rdata = req_addr ^ 32'h0F0F_0F0F;
        for (int i = 0; i < NC; i++) core_rdata[i*32 +: 32] = req_addr ^ (32'h1111_1111 * (i + 1));
    end

    mmio_gate u_mmio_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_strb(req_strb),
        .sel_rom(sel_rom), .sel_ram(sel_ram), .core_sel(core_sel),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .core_rdata(core_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_denied(rsp_denied),
        .app_mode(app_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    // expectation for one request; updates the model afterwards
    task automatic model(input logic [31:0] a, input bit w, input logic [31:0] d, input logic [3:0] s,
                         output logic [7:0] esel, output bit eden, output logic [31:0] erd,
                         output string tag);
        logic [7:0] pre = a[31:24];
        logic [31:0] src = '0;
        int ci = -1;
        int wd = int'(a[7:2]);
        logic [7:0] pfx [NC] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hD0};
        esel = '0; eden = 0; tag = "R1";
        if (a[31:30] == 2'b00) begin esel[0] = 1; src = a ^ 32'h5A5A_0000; end
        else if (a[31:30] == 2'b01) begin esel[1] = 1; src = a ^ 32'h0F0F_0F0F; end
        else if (a[31:30] == 2'b10) begin eden = 1; tag = "R9"; end
        else begin
            for (int i = 0; i < NC; i++) if (pre == pfx[i]) ci = i;
            tag = "R2";
            if (ci >= 0) begin
                if (m_mode && (ci == 2 || ci == 5)) begin eden = 1; tag = "R5"; end
                else begin esel[2 + ci] = 1; src = a ^ (32'h1111_1111 * (ci + 1)); end
            end else if (pre != 8'hFF) begin eden = 1; tag = "R9"; end
            else if (a[23:8] != 0 || a[1:0] != 0) begin eden = 1; tag = "R9"; end
            else if (wd <= 2) begin
                tag = "R8";
                if (w) eden = 1;
                else src = (wd == 0) ? 32'h3161_746D : (wd == 1) ? 32'h6664_6B6D : 32'h1;
            end else if (wd == 4) begin
                tag = m_mode ? "R5" : (w ? "R4" : "R10");
                if (m_mode) eden = 1;
                else if (w && ((d & {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}}) != 0)) m_mode = 1;
            end else if (wd == 8 || wd == 9) begin
                tag = "R6";
                if (!w) src = (wd == 8) ? m_base : m_len;
                else if (m_mode) eden = 1;
                else if (wd == 8) m_base = merge(m_base, d, s);
                else m_len = merge(m_len, d, s);
            end else if (wd >= 16 && wd < 24) begin
                tag = "R7";
                if (!w) src = m_cdi[wd - 16];
                else if (m_mode) eden = 1;
                else m_cdi[wd - 16] = merge(m_cdi[wd - 16], d, s);
            end else begin eden = 1; tag = "R9"; end
        end
        erd = (eden || w) ? 32'h0 : src;
    endtask

    task automatic access(input logic [31:0] a, input bit w, input logic [31:0] d, input logic [3:0] s);
        logic [7:0] esel; bit eden; logic [31:0] erd; string tag; bit mode_after;
        model(a, w, d, s, esel, eden, erd, tag);
        mode_after = m_mode;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_we = w; req_wdata = d; req_strb = s;
        #1;
        chk({tag, " selects (R1/R2)"}, {24'h0, core_sel, sel_ram, sel_rom}, {24'h0, esel});
        @(negedge clk);
        req_valid = 0; req_we = 0;
        chk("R3 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk({tag, " denied"}, {31'h0, rsp_denied}, {31'h0, eden});
        chk({tag, " rdata"}, rsp_rdata, erd);
        chk("R4 app_mode", {31'h0, app_mode}, {31'h0, mode_after});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; req_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_mode = 0; m_base = '0; m_len = '0;
        for (int i = 0; i < 8; i++) m_cdi[i] = '0;
        chk("R4 reset mode", {31'h0, app_mode}, 32'h0);
        chk("R3 reset rsp", {30'h0, rsp_valid, rsp_denied}, 32'h0);
        chk("R3 ready", {31'h0, req_ready}, 32'h1);
    endtask

    function automatic logic [31:0] rand_addr();
        logic [7:0] pfx [9] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hD0, 8'hC5, 8'hE0, 8'hFF};
        int wl [14] = '{0, 1, 2, 3, 4, 8, 9, 16, 17, 19, 23, 24, 30, 12};
        int k = $urandom_range(0, 9);
        logic [31:0] r = $urandom;
        if (k == 0) return {2'b00, r[29:0]};
        if (k == 1) return {2'b01, r[29:0]};
        if (k == 2) return {2'b10, r[29:0]};
        if (k < 6) return {pfx[$urandom_range(0, 8)], r[23:2], 2'b00};
        if (k == 6) return {8'hFF, r[23:0]};
        return {8'hFF, 16'h0, 6'(wl[$urandom_range(0, 13)]), 2'b00};
    endfunction

    initial begin
        void'($urandom(32'd20241));
        do_reset();
        // directed corner cases
        access(32'hFF00_0000, 0, 0, 4'hF);          // R8
        access(32'hFF00_0004, 0, 0, 4'hF);          // R8
        access(32'hFF00_0008, 0, 0, 4'hF);          // R8
        access(32'hFF00_0000, 1, 32'hDEAD, 4'hF);   // R8 write denied
        access(32'hFF00_0020, 1, 32'hAABB_CCDD, 4'b0101); // R6 strobes
        access(32'hFF00_0020, 0, 0, 4'h0);          // R6
        access(32'hFF00_0054, 1, 32'h1234_5678, 4'hF);    // R7
        access(32'hFF00_0054, 0, 0, 4'h0);          // R7
        access(32'hFF00_0010, 0, 0, 4'h0);          // R10
        access(32'hFF00_0010, 1, 32'h0000_00FF, 4'b1110); // R4 masked to zero
        access(32'hD000_0040, 0, 0, 4'h0);          // R2 private RAM in boot mode
        access(32'h8000_0000, 0, 0, 4'h0);          // R9 reserved
        access(32'hFF00_0102, 0, 0, 4'h0);          // R9 bad offset
        access(32'hFF00_0010, 1, 32'h1, 4'h1);      // R4 switch
        access(32'hC200_0000, 0, 0, 4'h0);          // R5
        access(32'hD000_0000, 1, 32'h5, 4'hF);      // R5
        access(32'hFF00_0010, 0, 0, 4'h0);          // R5
        access(32'hFF00_0020, 1, 32'h0, 4'hF);      // R6 frozen
        access(32'hFF00_0020, 0, 0, 4'h0);          // R6
        access(32'hFF00_0054, 1, 32'h0, 4'hF);      // R7 frozen
        access(32'hFF00_0054, 0, 0, 4'h0);          // R7
        do_reset();                                 // R4 reset returns boot mode
        access(32'hC200_0010, 0, 0, 4'h0);          // R2 key core visible again
        // random mix with two resets
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a = rand_addr();
            bit w = $urandom_range(0, 1);
            logic [31:0] d = $urandom;
            if (a == 32'hFF00_0010 && w && $urandom_range(0, 3) != 0) d = 0;
            if (n == 200 || n == 400) do_reset();
            access(a, w, d, 4'($urandom));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule